// File: doc/BRIEF.md
# Operand Effective-Address Resolver

This block fetches the operand for an accumulator machine. A request carries a 3-bit addressing mode, a 16-bit field taken from the instruction, and a 4-bit register selector. The block works out where the operand lives and returns it, along with the effective address it used and a one-cycle done strobe. Depending on the mode it performs zero, one or two reads through a synchronous memory read port. Read data arrives one cycle after the read enable. The selected register is read through a combinational register-file read port.

A state machine drives the sequence. The states are IDLE, EVAL, PTR_RD, PTR_WT, OPN_RD, OPN_WT and FINISH. In IDLE the block is ready, and a valid request moves it to EVAL. In EVAL the register is read and the address is computed. From EVAL the machine goes to FINISH for modes that need no memory, to OPN_RD for modes that need one read, and to PTR_RD for the indirect mode. PTR_RD issues the pointer read, and PTR_WT captures the pointer as the new address before moving to OPN_RD. OPN_RD issues the operand read, OPN_WT captures the operand, and FINISH raises done and returns to IDLE.

Top module: `operand_resolver`

## Requirements
- R1: `req_ready_o` is high only in IDLE, and a request is taken only on a clock edge where `req_valid_i` and `req_ready_o` are both high. A `req_valid_i` raised while busy is ignored and has no effect on the result of the request in progress. No read and no done occur while ready.
- R2: Mode code 0 (immediate) gives operand = field and effective address = 0. It performs no memory read, and done appears one cycle after the accept edge.
- R3: Mode code 1 (direct) gives effective address = field[11:0] and operand = memory at that address. It performs one read, and done appears three cycles after the accept edge.
- R4: Mode code 2 (indirect) reads a pointer from memory at field[11:0]. The effective address is pointer[11:0], and the operand is memory at that address. It performs two reads, never on consecutive cycles, and done appears five cycles after the accept edge.
- R5: Mode code 3 (register) gives operand = the selected register and effective address = 0, with no memory read.
- R6: Mode code 4 (register indirect) gives effective address = selected register[11:0] and operand = memory at that address, with one read.
- R7: Mode code 5 (indexed) gives effective address = (field[11:0] + register[11:0]) modulo 4096 and operand = memory at that address, with one read.
- R8: Mode code 6 (based) gives effective address = (register[11:0] + field[7:0] sign-extended) modulo 4096 and operand = memory at that address, with one read. Field bits 15:8 are ignored.
- R9: Mode code 7 (reserved) gives operand = 0 and effective address = 0, with no read, and done one cycle after the accept edge.
- R10: `done_o` is a single-cycle pulse. While the block is idle with no request, `operand_o` and `ea_o` hold the values of the last completed request.
- R11: After reset `req_ready_o` = 1, and `done_o`, `mem_rd_en_o`, `operand_o` and `ea_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle and able to take a request |
| req_mode_i | input | 3 | Addressing mode code |
| req_field_i | input | 16 | Constant, address or displacement field |
| req_sel_i | input | 4 | Register selector |
| rf_sel_o | output | 4 | Register-file read select |
| rf_data_i | input | 16 | Register-file read data (combinational) |
| mem_rd_en_o | output | 1 | Memory read enable |
| mem_addr_o | output | 12 | Memory read address |
| mem_rdata_i | input | 16 | Memory read data, valid the cycle after the enable |
| done_o | output | 1 | Operand valid pulse |
| operand_o | output | 16 | Resolved operand |
| ea_o | output | 12 | Effective address used |

## Verification
The bench builds the block with its defaults: a 16-bit datapath, a 12-bit address, 16 registers and an 8-bit based displacement. It models the full 4096-word memory space. With these values, an indexed sum that carries past address 0xFFF and a negative based displacement that wraps below zero can both be driven. The bench also drives field bits above the address and displacement widths, to show that they are discarded. Per-mode latency and read counts are measured at the ports. A second request raised in the middle of an indirect fetch shows that the request is not taken.

// File: rtl/opr_pkg.sv
package opr_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        AM_IMM  = 3'd0,
        AM_DIR  = 3'd1,
        AM_IND  = 3'd2,
        AM_REG  = 3'd3,
        AM_RIND = 3'd4,
        AM_IDX  = 3'd5,
        AM_BASE = 3'd6,
        AM_RSV  = 3'd7
    } amode_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_EVAL,
        S_PTR_RD,
        S_PTR_WT,
        S_OPN_RD,
        S_OPN_WT,
        S_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        RT_NONE,
        RT_MEM,
        RT_PTR
    } route_t;

endpackage

// File: rtl/opr_addr_gen.sv
module opr_addr_gen
    import opr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int DISP_W = 8
) (
    input  amode_t              mode_i,
    input  logic [DATA_W-1:0]   field_i,
    input  logic [DATA_W-1:0]   reg_i,
    output route_t              route_o,
    output logic [ADDR_W-1:0]   ea_o,
    output logic [DATA_W-1:0]   value_o
);

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] idx_ea;
    logic [ADDR_W-1:0] base_ea;

    generate
        if (DISP_W >= ADDR_W) begin : g_wide_disp
            assign disp_ext = field_i[ADDR_W-1:0];
        end else begin : g_narrow_disp
            assign disp_ext = {{(ADDR_W-DISP_W){field_i[DISP_W-1]}}, field_i[DISP_W-1:0]};
        end
    endgenerate

    assign idx_ea  = field_i[ADDR_W-1:0] + reg_i[ADDR_W-1:0];
    assign base_ea = reg_i[ADDR_W-1:0] + disp_ext;

    always_comb begin
        route_o = RT_NONE;
        ea_o    = '0;
        value_o = '0;
        unique case (mode_i)
            AM_IMM: begin
                value_o = field_i;
            end
            AM_DIR: begin
                route_o = RT_MEM;
                ea_o    = field_i[ADDR_W-1:0];
            end
            AM_IND: begin
                route_o = RT_PTR;
                ea_o    = field_i[ADDR_W-1:0];
            end
            AM_REG: begin
                value_o = reg_i;
            end
            AM_RIND: begin
                route_o = RT_MEM;
                ea_o    = reg_i[ADDR_W-1:0];
            end
            AM_IDX: begin
                route_o = RT_MEM;
                ea_o    = idx_ea;
            end
            AM_BASE: begin
                route_o = RT_MEM;
                ea_o    = base_ea;
            end
            AM_RSV: begin
                route_o = RT_NONE;
            end
        endcase
    end

endmodule

// File: rtl/opr_seq.sv
module opr_seq
    import opr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid_i,
    input  route_t route_i,
    output logic   req_ready_o,
    output logic   done_o,
    output logic   mem_rd_en_o,
    output logic   cap_req_o,
    output logic   ld_eval_o,
    output logic   ld_val_o,
    output logic   ld_ptr_o,
    output logic   ld_opnd_o
);

    seq_state_t state_q;
    seq_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid_i) state_d = S_EVAL;
            end
            S_EVAL: begin
                case (route_i)
                    RT_MEM:  state_d = S_OPN_RD;
                    RT_PTR:  state_d = S_PTR_RD;
                    default: state_d = S_FINISH;
                endcase
            end
            S_PTR_RD: state_d = S_PTR_WT;
            S_PTR_WT: state_d = S_OPN_RD;
            S_OPN_RD: state_d = S_OPN_WT;
            S_OPN_WT: state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_comb begin
        req_ready_o = 1'b0;
        done_o      = 1'b0;
        mem_rd_en_o = 1'b0;
        cap_req_o   = 1'b0;
        ld_eval_o   = 1'b0;
        ld_val_o    = 1'b0;
        ld_ptr_o    = 1'b0;
        ld_opnd_o   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                req_ready_o = 1'b1;
                cap_req_o   = req_valid_i;
            end
            S_EVAL: begin
                ld_eval_o = 1'b1;
                ld_val_o  = (route_i == RT_NONE);
            end
            S_PTR_RD: mem_rd_en_o = 1'b1;
            S_PTR_WT: ld_ptr_o    = 1'b1;
            S_OPN_RD: mem_rd_en_o = 1'b1;
            S_OPN_WT: ld_opnd_o   = 1'b1;
            S_FINISH: done_o      = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/opr_hold.sv
module opr_hold
    import opr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int SEL_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_req_i,
    input  logic [MODE_W-1:0]   mode_i,
    input  logic [DATA_W-1:0]   field_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic                ld_eval_i,
    input  logic                ld_val_i,
    input  logic [ADDR_W-1:0]   eval_ea_i,
    input  logic [DATA_W-1:0]   eval_val_i,
    input  logic                ld_ptr_i,
    input  logic                ld_opnd_i,
    input  logic [DATA_W-1:0]   rdata_i,
    output amode_t              mode_o,
    output logic [DATA_W-1:0]   field_o,
    output logic [SEL_W-1:0]    sel_o,
    output logic [ADDR_W-1:0]   ea_o,
    output logic [DATA_W-1:0]   operand_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o  <= AM_IMM;
            field_o <= '0;
            sel_o   <= '0;
        end else if (cap_req_i) begin
            mode_o  <= amode_t'(mode_i);
            field_o <= field_i;
            sel_o   <= sel_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_o <= '0;
        end else if (ld_eval_i) begin
            ea_o <= eval_ea_i;
        end else if (ld_ptr_i) begin
            ea_o <= rdata_i[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            operand_o <= '0;
        end else if (ld_val_i) begin
            operand_o <= eval_val_i;
        end else if (ld_opnd_i) begin
            operand_o <= rdata_i;
        end
    end

endmodule

// File: rtl/operand_resolver.sv
module operand_resolver
    import opr_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 16,
    parameter int DISP_W   = 8,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid_i,
    output logic                req_ready_o,
    input  logic [MODE_W-1:0]   req_mode_i,
    input  logic [DATA_W-1:0]   req_field_i,
    input  logic [SEL_W-1:0]    req_sel_i,
    output logic [SEL_W-1:0]    rf_sel_o,
    input  logic [DATA_W-1:0]   rf_data_i,
    output logic                mem_rd_en_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    input  logic [DATA_W-1:0]   mem_rdata_i,
    output logic                done_o,
    output logic [DATA_W-1:0]   operand_o,
    output logic [ADDR_W-1:0]   ea_o
);

    amode_t              mode_q;
    logic [DATA_W-1:0]   field_q;
    logic [SEL_W-1:0]    sel_q;
    logic [ADDR_W-1:0]   ea_q;
    route_t              route;
    logic [ADDR_W-1:0]   calc_ea;
    logic [DATA_W-1:0]   calc_val;
    logic                cap_req;
    logic                ld_eval;
    logic                ld_val;
    logic                ld_ptr;
    logic                ld_opnd;

    opr_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .route_i     (route),
        .req_ready_o (req_ready_o),
        .done_o      (done_o),
        .mem_rd_en_o (mem_rd_en_o),
        .cap_req_o   (cap_req),
        .ld_eval_o   (ld_eval),
        .ld_val_o    (ld_val),
        .ld_ptr_o    (ld_ptr),
        .ld_opnd_o   (ld_opnd)
    );

    opr_addr_gen #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W)
    ) u_agen (
        .mode_i  (mode_q),
        .field_i (field_q),
        .reg_i   (rf_data_i),
        .route_o (route),
        .ea_o    (calc_ea),
        .value_o (calc_val)
    );

    opr_hold #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .SEL_W  (SEL_W)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_req_i  (cap_req),
        .mode_i     (req_mode_i),
        .field_i    (req_field_i),
        .sel_i      (req_sel_i),
        .ld_eval_i  (ld_eval),
        .ld_val_i   (ld_val),
        .eval_ea_i  (calc_ea),
        .eval_val_i (calc_val),
        .ld_ptr_i   (ld_ptr),
        .ld_opnd_i  (ld_opnd),
        .rdata_i    (mem_rdata_i),
        .mode_o     (mode_q),
        .field_o    (field_q),
        .sel_o      (sel_q),
        .ea_o       (ea_q),
        .operand_o  (operand_o)
    );

    assign rf_sel_o   = sel_q;
    assign mem_addr_o = ea_q;
    assign ea_o       = ea_q;

endmodule

// File: rtl/opr_checker.sv
module opr_checker #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic [2:0]        req_mode_i,
    input logic [DATA_W-1:0] req_field_i,
    input logic              done_o,
    input logic              mem_rd_en_o,
    input logic [DATA_W-1:0] operand_o,
    input logic [ADDR_W-1:0] ea_o
);

    p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> (!mem_rd_en_o && !done_o));

    p_imm_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && req_mode_i == 3'd0)
        |=> ##1 (done_o && operand_o == $past(req_field_i, 2) && ea_o == '0));

    p_reads_spaced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> !mem_rd_en_o);

    p_rsv_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && req_mode_i == 3'd7)
        |=> ##1 (done_o && operand_o == '0 && ea_o == '0));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready_o && !req_valid_i) |=> ($stable(operand_o) && $stable(ea_o)));

endmodule

bind operand_resolver opr_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_opr_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_mode_i  (req_mode_i),
    .req_field_i (req_field_i),
    .done_o      (done_o),
    .mem_rd_en_o (mem_rd_en_o),
    .operand_o   (operand_o),
    .ea_o        (ea_o)
);

// File: tb/test_operand_resolver.sv
`timescale 1ns/1ps
module test_operand_resolver;

    typedef struct {
        logic [15:0] op;
        logic [11:0] ea;
        int          rd;
        string       tag;
    } exp_t;

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [2:0]  req_mode;
    logic [15:0] req_field;
    logic [3:0]  req_sel;
    logic [3:0]  rf_sel;
    logic [15:0] rf_data;
    logic        mem_rd_en;
    logic [11:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        done;
    logic [15:0] operand;
    logic [11:0] ea;

    logic [15:0] mem  [0:4095];
    logic [15:0] regs [0:15];
    exp_t        q[$];
    int          checks;
    int          failures;
    int          lat;
    int          nrd;
    bit          finished;
    bit          chk_next;
    logic [15:0] last_op;
    logic [11:0] last_ea;

    operand_resolver i_operand_resolver (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_ready_o (req_ready),
        .req_mode_i  (req_mode),
        .req_field_i (req_field),
        .req_sel_i   (req_sel),
        .rf_sel_o    (rf_sel),
        .rf_data_i   (rf_data),
        .mem_rd_en_o (mem_rd_en),
        .mem_addr_o  (mem_addr),
        .mem_rdata_i (mem_rdata),
        .done_o      (done),
        .operand_o   (operand),
        .ea_o        (ea)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    assign rf_data = regs[rf_sel];

    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
    end

    always @(posedge clk) begin
        if (req_valid && req_ready) begin
            lat <= 0;
            nrd <= 0;
        end else begin
            lat <= lat + 1;
            if (mem_rd_en) nrd <= nrd + 1;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic void model(input logic [2:0] m, input logic [15:0] f,
                                  input logic [3:0] s, output logic [15:0] op,
                                  output logic [11:0] a, output int rd);
        logic [15:0] r;
        r = regs[s];
        op = '0;
        a  = '0;
        rd = 0;
        case (m)
            3'd0: op = f;
            3'd1: begin a = f[11:0]; op = mem[a]; rd = 1; end
            3'd2: begin a = mem[f[11:0]][11:0]; op = mem[a]; rd = 2; end
            3'd3: op = r;
            3'd4: begin a = r[11:0]; op = mem[a]; rd = 1; end
            3'd5: begin a = f[11:0] + r[11:0]; op = mem[a]; rd = 1; end
            3'd6: begin a = r[11:0] + {{4{f[7]}}, f[7:0]}; op = mem[a]; rd = 1; end
            default: ;
        endcase
    endfunction

    task automatic issue(input logic [2:0] m, input logic [15:0] f,
                         input logic [3:0] s, input string tag);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_mode  = m;
        req_field = f;
        req_sel   = s;
        model(m, f, s, e.op, e.ea, e.rd);
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic poke_busy();
        @(negedge clk);
        while (req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_mode  = 3'd0;
        req_field = 16'hDEAD;
        req_sel   = 4'd0;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        if (chk_next) begin
            chk_next = 1'b0;
            chk("R10", "done pulse width", {31'd0, done}, 32'd0);
        end else if (rst_n && done) begin
            if (q.size() == 0) begin
                chk("R1", "unexpected done", 32'd1, 32'd0);
            end else begin
                e = q.pop_front();
                chk(e.tag, "operand", {16'd0, operand}, {16'd0, e.op});
                chk(e.tag, "ea", {20'd0, ea}, {20'd0, e.ea});
                chk(e.tag, "reads", nrd, e.rd);
                chk(e.tag, "latency", lat, 1 + 2 * e.rd);
                last_op = e.op;
                last_ea = e.ea;
            end
            chk_next = 1'b1;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        checks    = 0;
        failures  = 0;
        finished  = 1'b0;
        chk_next  = 1'b0;
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_mode  = '0;
        req_field = '0;
        req_sel   = '0;
        mem_rdata = '0;
        for (int i = 0; i < 4096; i++) mem[i] = 16'((i * 40503 + 7) ^ (i << 5));
        for (int i = 0; i < 16; i++) regs[i] = 16'(i * 16'h0111 + 3);
        mem[12'h200] = 16'h7345;
        mem[12'h345] = 16'hCAFE;
        mem[12'h0A0] = 16'hF0FF;
        regs[2] = 16'h0002;
        regs[4] = 16'h0010;
        regs[1] = 16'h0005;
        regs[7] = 16'h1ABC;

        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11", "ready", {31'd0, req_ready}, 32'd1);
        chk("R11", "done", {31'd0, done}, 32'd0);
        chk("R11", "rd_en", {31'd0, mem_rd_en}, 32'd0);
        chk("R11", "operand", {16'd0, operand}, 32'd0);
        chk("R11", "ea", {20'd0, ea}, 32'd0);
        rst_n = 1'b1;

        issue(3'd0, 16'hBEEF, 4'd3, "R2");
        issue(3'd0, 16'h0000, 4'd9, "R2");
        issue(3'd1, 16'h0123, 4'd0, "R3");
        issue(3'd1, 16'hF456, 4'd0, "R3");
        issue(3'd2, 16'h0200, 4'd0, "R4");
        issue(3'd2, 16'h90A0, 4'd0, "R4");
        issue(3'd3, 16'h1111, 4'd5, "R5");
        issue(3'd3, 16'h0000, 4'd15, "R5");
        issue(3'd4, 16'h0000, 4'd7, "R6");
        issue(3'd5, 16'h0FFF, 4'd2, "R7");
        issue(3'd5, 16'hE100, 4'd9, "R7");
        issue(3'd6, 16'h00F0, 4'd4, "R8");
        issue(3'd6, 16'hAB05, 4'd4, "R8");
        issue(3'd6, 16'h0080, 4'd1, "R8");
        issue(3'd7, 16'h1234, 4'd6, "R9");
        drain();

        // R1: request raised during an indirect fetch is not taken
        issue(3'd2, 16'h0200, 4'd0, "R1");
        poke_busy();
        drain();
        chk("R1", "ready after busy poke", {31'd0, req_ready}, 32'd1);
        chk("R1", "queue empty", q.size(), 0);

        // R10: outputs hold while idle
        repeat (6) @(negedge clk);
        chk("R10", "hold operand", {16'd0, operand}, {16'd0, last_op});
        chk("R10", "hold ea", {20'd0, ea}, {20'd0, last_ea});

        // mixed stream over every mode
        for (int k = 0; k < 24; k++) begin
            issue(3'(k % 8), 16'(k * 16'h1357 + 16'h0421), 4'(k * 5), "R3");
        end
        drain();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule